// File: doc/BRIEF.md
# Framed SPI Register Slave

This block lets a host controller reach a small bank of byte-wide registers over a four-wire serial link. Each chip-select low period carries one 16-bit word. The host sends a command byte and then a data byte. While those bits arrive, the block returns a byte of fault flags, followed by either the selected register's contents (read) or zeros (write). All serial pins are synchronized into the system clock. Edges of the serial clock and of chip select are detected in that domain, so the system clock must run at least four times faster than the serial clock.

A write takes effect only when chip select returns high after exactly sixteen serial clock falling edges. If the edge count is different, the word is thrown away and a sticky frame-error flag is set. That flag is the top bit of the fault byte. A write to configuration register 0 with its bit 0 set clears the flag.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset every configuration register reads 0x00, `spi_miso_oe` is 0, and the frame-error flag is clear.
- R2: `spi_miso_oe` is 0 while chip select is high and 1 while it is low, each after a few system clocks of synchronizer delay.
- R3: The first eight bits shifted out, MSB first, form the fault byte {frame_error, fault_in[6:0]}, taken when chip select falls. The host samples output bits on serial clock falling edges.
- R4: A command byte has bit 7 = 0 (reserved) and bit 6 = 1 (read), and bits 5:0 give the address. For such a command the second output byte, MSB first, is the addressed register. Configuration registers sit at addresses 0..NCFG-1. Read-only status registers sit at STAT_BASE+i (default 0x10, 0x11) and return byte i of `status_in`.
- R5: A command with bit 7 = 0 and bit 6 = 0 writes the data byte (input bits are sampled on serial clock falling edges, MSB first) to the addressed configuration register. The write commits when chip select rises after exactly 16 falling edges. The second output byte is 0x00.
- R6: A frame with fewer or more than 16 falling edges, including zero, changes no register and sets the sticky frame-error flag.
- R7: Writing configuration register 0 with data bit 0 = 1 clears the frame-error flag. Bit 0 of register 0 is never stored and reads 0. Its other bits are stored normally.
- R8: Writes to status or unimplemented addresses are ignored. Reads of unimplemented addresses return 0x00.
- R9: A command with bit 7 = 1 writes nothing and returns 0x00 as its second byte.
- R10: Serial clock and data activity while chip select is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the external tristate buffer on `spi_miso` |
| fault_in | input | 7 | Fault flags reported in the fault byte |
| status_in | input | NSTAT*8 | Read-only status register contents |
| cfg_out | output | NCFG*8 | Configuration register contents, register i at bits [8i+7:8i] |

## Verification
The frames used are:
- reads of configuration, status and unimplemented addresses;
- writes to writable, read-only and unimplemented addresses;
- frames with 0, 12 and 17 clock edges;
- commands with the reserved bit set;
- serial clock toggling while chip select is high.

Read frames show whether the second byte comes from the right source. Writes to non-writable addresses show whether the write decode is gated. The mis-counted frames show whether commit depends on an exact count of sixteen, and whether the error flag is set and later cleared. Fault-byte checks use a non-symmetric fault pattern, so bit order and bit position are both exposed.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int ADDR_W     = 6;
  localparam int FAULT_W    = BYTE_W - 1;

  typedef struct packed {
    logic              rsvd;
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } spi_cmd_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int             N       = 3,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] status_byte,
  input  logic [BYTE_W-1:0] rd_byte,
  output spi_cmd_t          cmd_q,
  output logic [BYTE_W-1:0] wdata,
  output logic              frame_end,
  output logic              frame_ok,
  output logic              miso_q,
  output logic              miso_oe_q
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(BYTE_W - 1);

  logic                  cs_d, sclk_d;
  logic                  cs_fall, cs_rise, sck_rise, sck_fall;
  logic [CNT_W-1:0]      fall_cnt;
  logic [BYTE_W-1:0]     rx;
  logic [FRAME_BITS-1:0] tx;
  logic                  cmd_valid;

  assign cs_fall  = cs_d & ~cs_n;
  assign cs_rise  = ~cs_d & cs_n;
  assign sck_rise = ~sclk_d & sclk;
  assign sck_fall = sclk_d & ~sclk;
  assign wdata    = rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d      <= 1'b1;
      sclk_d    <= 1'b0;
      fall_cnt  <= '0;
      rx        <= '0;
      tx        <= '0;
      cmd_q     <= '0;
      cmd_valid <= 1'b0;
      frame_end <= 1'b0;
      frame_ok  <= 1'b0;
      miso_q    <= 1'b0;
      miso_oe_q <= 1'b0;
    end else begin
      cs_d      <= cs_n;
      sclk_d    <= sclk;
      miso_oe_q <= ~cs_n;
      cmd_valid <= 1'b0;
      frame_end <= 1'b0;
      if (cs_fall) begin
        fall_cnt <= '0;
        tx       <= {status_byte, {BYTE_W{1'b0}}};
        miso_q   <= status_byte[BYTE_W-1];
      end else if (cs_rise) begin
        frame_end <= 1'b1;
        frame_ok  <= (fall_cnt == CNT_FULL);
      end else if (!cs_n) begin
        if (sck_fall) begin
          rx <= {rx[BYTE_W-2:0], mosi};
          if (fall_cnt != CNT_SAT) fall_cnt <= fall_cnt + 1'b1;
          if (fall_cnt == CNT_CMD) begin
            cmd_q     <= {rx[BYTE_W-2:0], mosi};
            cmd_valid <= 1'b1;
          end
        end
        if (sck_rise) begin
          miso_q <= tx[FRAME_BITS-1];
          tx     <= {tx[FRAME_BITS-2:0], 1'b0};
        end else if (cmd_valid) begin
          tx[FRAME_BITS-1 -: BYTE_W] <= rd_byte;
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_reg_pkg::*;
#(
  parameter int NCFG      = 4,
  parameter int NSTAT     = 2,
  parameter int STAT_BASE = 16,
  parameter int CLR_BIT   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [BYTE_W-1:0]       rd_data,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [NSTAT*BYTE_W-1:0] status_in,
  output logic [NCFG*BYTE_W-1:0]  cfg_out,
  output logic                    clr_req
);
  logic [BYTE_W-1:0] cfg_q [NCFG];
  localparam logic [BYTE_W-1:0] KEEP0 = ~(BYTE_W'(1) << CLR_BIT);

  assign clr_req = wr_en && (wr_addr == '0) && wr_data[CLR_BIT];

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam logic [BYTE_W-1:0] MASK = (g == 0) ? KEEP0 : '1;
    always_ff @(posedge clk) begin
      if (rst) cfg_q[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g)) cfg_q[g] <= wr_data & MASK;
    end
    assign cfg_out[g*BYTE_W +: BYTE_W] = cfg_q[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCFG; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = cfg_q[i];
    for (int i = 0; i < NSTAT; i++)
      if (rd_addr == ADDR_W'(STAT_BASE + i)) rd_data = status_in[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int NCFG      = 4,
  parameter int NSTAT     = 2,
  parameter int STAT_BASE = 16,
  parameter int SYNC_STG  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    spi_cs_n,
  input  logic                    spi_sclk,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  output logic                    spi_miso_oe,
  input  logic [FAULT_W-1:0]      fault_in,
  input  logic [NSTAT*BYTE_W-1:0] status_in,
  output logic [NCFG*BYTE_W-1:0]  cfg_out
);
  logic [2:0]        pins_s;
  spi_cmd_t          cmd;
  logic [BYTE_W-1:0] wdata, rf_rd, rd_byte, status_byte;
  logic              frame_end, frame_ok, wr_en, clr_req, err_q;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst(rst),
    .din({spi_cs_n, spi_sclk, spi_mosi}),
    .dout(pins_s)
  );

  assign status_byte = {err_q, fault_in};
  assign rd_byte     = (cmd.rd && !cmd.rsvd) ? rf_rd : '0;
  assign wr_en       = frame_end && frame_ok && !cmd.rsvd && !cmd.rd;

  spi_frame_engine i_eng (
    .clk(clk), .rst(rst),
    .cs_n(pins_s[2]), .sclk(pins_s[1]), .mosi(pins_s[0]),
    .status_byte(status_byte), .rd_byte(rd_byte),
    .cmd_q(cmd), .wdata(wdata),
    .frame_end(frame_end), .frame_ok(frame_ok),
    .miso_q(spi_miso), .miso_oe_q(spi_miso_oe)
  );

  spi_reg_file #(.NCFG(NCFG), .NSTAT(NSTAT), .STAT_BASE(STAT_BASE)) i_rf (
    .clk(clk), .rst(rst),
    .rd_addr(cmd.addr), .rd_data(rf_rd),
    .wr_en(wr_en), .wr_addr(cmd.addr), .wr_data(wdata),
    .status_in(status_in), .cfg_out(cfg_out), .clr_req(clr_req)
  );

  always_ff @(posedge clk) begin
    if (rst)                        err_q <= 1'b0;
    else if (frame_end && !frame_ok) err_q <= 1'b1;
    else if (clr_req)               err_q <= 1'b0;
  end
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             spi_cs_n,
  input logic             spi_miso_oe,
  input logic [CFG_W-1:0] cfg_out,
  input logic             wr_en,
  input logic             frame_end,
  input logic             frame_ok,
  input logic             clr_req,
  input logic             err_q
);
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe); // R2
  AST_OE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && !$past(spi_cs_n) && !$past(spi_cs_n, 2) && !$past(spi_cs_n, 3)) |-> spi_miso_oe); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(cfg_out)); // R5
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(frame_end && !frame_ok)); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> $past(clr_req)); // R7
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.CFG_W(NCFG*8)) i_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .cfg_out(cfg_out), .wr_en(wr_en), .frame_end(frame_end),
  .frame_ok(frame_ok), .clr_req(clr_req), .err_q(err_q)
);

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [6:0]  fault_in = 7'h15;
  logic [15:0] status_in = 16'h3CC3;
  logic [31:0] cfg_out;

  int n_cmp = 0, n_bad = 0;
  bit err_m = 1'b0;

  typedef struct { logic [15:0] word; bit chk; string req; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  spi_reg_slave i_spi_reg_slave (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .fault_in(fault_in), .status_in(status_in), .cfg_out(cfg_out)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat();
    return {err_m, fault_in};
  endfunction

  task automatic frame(input logic [7:0] cmd, input logic [7:0] data, input int nbits,
                       input logic [7:0] exp_lo, input bit chk, input string req);
    exp_t e;
    logic [15:0] din;
    din = {cmd, data};
    e.word = {stat(), exp_lo}; e.chk = chk; e.req = req;
    exp_q.push_back(e);
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      spi_mosi = (b < 16) ? din[15-b] : 1'b0;
      spi_sclk = 1'b1;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
    if (nbits != 16) err_m = 1'b1;
  endtask

  // monitor: collects each frame's output bits and compares with the scoreboard
  initial begin
    forever begin
      logic [15:0] w;
      int n;
      exp_t e;
      @(negedge spi_cs_n);
      w = '0; n = 0;
      forever begin
        @(negedge spi_sclk or posedge spi_cs_n);
        if (spi_cs_n) break;
        w = {w[14:0], spi_miso};
        n++;
      end
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: actual frame %h expected none", w);
      end else begin
        e = exp_q.pop_front();
        if (e.chk) check({n[15:0], w}, {16'd16, e.word}, e.req);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(cfg_out, 32'h0, "R1 cfg reset");
    check({31'h0, spi_miso_oe}, 32'h0, "R1 oe reset");
    // R3 R4 R1: read cfg0, fault byte with error clear
    frame(8'h40, 8'h00, 16, 8'h00, 1, "R3 R4 R1 read cfg0");
    // R5 write cfg1
    frame(8'h01, 8'hA5, 16, 8'h00, 1, "R5 write cfg1");
    check(cfg_out, 32'h0000A500, "R5 cfg1 committed");
    frame(8'h41, 8'h00, 16, 8'hA5, 1, "R4 read cfg1");
    frame(8'h50, 8'h00, 16, 8'hC3, 1, "R4 read status0");
    frame(8'h51, 8'h00, 16, 8'h3C, 1, "R4 read status1");
    // R8 ignored writes and unimplemented read
    frame(8'h10, 8'hFF, 16, 8'h00, 1, "R8 write status0");
    frame(8'h50, 8'h00, 16, 8'hC3, 1, "R8 status0 unchanged");
    frame(8'h20, 8'h5A, 16, 8'h00, 1, "R8 write unimpl");
    frame(8'h60, 8'h00, 16, 8'h00, 1, "R8 read unimpl");
    check(cfg_out, 32'h0000A500, "R8 cfg unchanged");
    // R6 short and long frames
    frame(8'h02, 8'h77, 12, 8'h00, 0, "R6 short");
    check(cfg_out, 32'h0000A500, "R6 short ignored");
    frame(8'h42, 8'h00, 16, 8'h00, 1, "R6 err flag after short");
    frame(8'h03, 8'h66, 17, 8'h00, 0, "R6 long");
    check(cfg_out, 32'h0000A500, "R6 long ignored");
    // R7 clear via cfg0 bit0
    frame(8'h00, 8'h81, 16, 8'h00, 1, "R7 clear write");
    err_m = 1'b0;
    check(cfg_out, 32'h0000A580, "R7 cfg0 bit0 not stored");
    frame(8'h40, 8'h00, 16, 8'h80, 1, "R7 err cleared");
    // R9 reserved bit
    frame(8'h81, 8'h11, 16, 8'h00, 1, "R9 rsvd write");
    check(cfg_out, 32'h0000A580, "R9 no write");
    frame(8'hC1, 8'h00, 16, 8'h00, 1, "R9 rsvd read");
    // R2 oe and zero-edge frame
    exp_q.push_back('{16'h0, 1'b0, "R2"});
    spi_cs_n = 1'b0;
    repeat (8) @(negedge clk);
    check({31'h0, spi_miso_oe}, 32'h1, "R2 oe active");
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check({31'h0, spi_miso_oe}, 32'h0, "R2 oe idle");
    err_m = 1'b1;
    frame(8'h41, 8'h00, 16, 8'hA5, 1, "R6 zero-edge frame flagged");
    frame(8'h00, 8'h01, 16, 8'h00, 1, "R7 clear again");
    err_m = 1'b0;
    check(cfg_out, 32'h0000A500, "R7 cfg0 rewritten");
    // R10 activity with cs high
    for (int k = 0; k < 20; k++) begin
      spi_mosi = k[0];
      spi_sclk = ~spi_sclk;
      repeat (H) @(negedge clk);
    end
    spi_sclk = 1'b0;
    repeat (8) @(negedge clk);
    check(cfg_out, 32'h0000A500, "R10 cfg untouched");
    fault_in = 7'h6A;
    frame(8'h41, 8'h00, 16, 8'hA5, 1, "R10 R3 no error after idle toggles");
    repeat (20) @(negedge clk);
    check(exp_q.size(), 0, "scoreboard drained");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule